// File: doc/BRIEF.md
# Shared-Bus Busy Flag and Address Snoop Monitor

This block sits beside a device that shares a two-wire open-drain serial bus and only watches it. It passes the data line and clock line through synchronisers, recognises the framing events (data falling while the clock is high opens a transfer, data rising while the clock is high closes it) and keeps a bus-busy flag from one to the other. It never drives either line.

After every opening event the monitor shifts in the first eight data samples taken on clock rising edges: seven address bits, most significant first, then the direction bit. It compares the seven address bits with the locally programmed address and reports whether they match, together with the direction bit. A local transmitter uses the permission output. Permission is granted while the bus is free. Permission is also granted once the captured address has matched, so that the local device can answer. Permission is withdrawn while an address is being collected. After an address that belongs to another device, permission stays withdrawn until the closing event.

Top module: `bus_snoop_monitor`

## Requirements
- R1: After reset the bus is taken as free: `bus_busy`=0, `tx_allowed`=1, `addr_match`=0, `rw_bit`=0, and no pulse is issued.
- R2: A falling data line while the clock line is high gives exactly one single-cycle `start_pulse` and sets `bus_busy` to 1.
- R3: A rising data line while the clock line is high gives exactly one single-cycle `stop_pulse`, clears `bus_busy` and sets `tx_allowed` to 1.
- R4: Data line changes while the clock line is low produce no `start_pulse` or `stop_pulse` and leave `bus_busy` unchanged.
- R5: After an opening event the first eight clock rising edges sample the address byte, with bit 7 (first) down to bit 1 forming the address and bit 0 (eighth) the direction bit. `addr_valid` pulses once for one cycle, and `rw_bit` shows the eighth bit (1 = read).
- R6: `addr_match` is 1 when the seven captured bits equal `own_addr`. After such a match `tx_allowed` is 1 until the next framing event.
- R7: When the captured address differs from `own_addr`, `tx_allowed` stays 0 until a closing event is seen.
- R8: From an opening event until `addr_valid`, `tx_allowed` is 0.
- R9: The ninth clock pulse (acknowledge slot) and later pulses produce no further `addr_valid` and do not change `addr_match` or `rw_bit`.
- R10: An opening event while busy (repeated start) keeps `bus_busy` at 1, clears `addr_match` and `rw_bit`, and starts a new address capture.
- R11: Clock pulses while the bus is free produce no `addr_valid`.
- R12: A closing event during address capture ends it: later clock pulses produce no `addr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Observed data line level |
| scl_in | input | 1 | Observed clock line level |
| own_addr | input | ADDR_W | Locally programmed device address |
| start_pulse | output | 1 | One-cycle pulse per opening event |
| stop_pulse | output | 1 | One-cycle pulse per closing event |
| bus_busy | output | 1 | Bus is between opening and closing events |
| addr_valid | output | 1 | One-cycle pulse when the address byte is complete |
| addr_match | output | 1 | Captured address equals own_addr |
| rw_bit | output | 1 | Captured direction bit, 1 = read |
| tx_allowed | output | 1 | Local transmitter may drive the bus |

## Verification
The main path is exercised with a table of address bytes: matching reads and writes, an address that differs only in its last bit, one that differs only in its first bit, and the all-zero and all-one patterns. Together these separate a correct shift order and comparison from a swapped bit order, an off-by-one sample count or a comparison that ignores an end bit. Data line toggles with the clock low, and clock pulses on a free bus, show that framing is judged only while the clock is high and that capture needs an opening event. A repeated start after a foreign address, and a closing event in the middle of an address, show that a new opening event restarts capture and that a closing event ends it.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int DEF_ADDR_W = 7;

  typedef enum logic [1:0] {
    PH_FREE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_OWNED = 2'd2,
    PH_HELD  = 2'd3
  } phase_e;
endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = din;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/snoop_cond_detect.sv
module snoop_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic bit_val
);
  logic sda_prev_q, scl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      scl_prev_q <= 1'b1;
    end else begin
      sda_prev_q <= sda_s;
      scl_prev_q <= scl_s;
    end
  end

  logic clk_high_both;
  always_comb begin
    clk_high_both = scl_prev_q & scl_s;
    start_det     = clk_high_both & sda_prev_q & ~sda_s;
    stop_det      = clk_high_both & ~sda_prev_q & sda_s;
    scl_rise      = ~scl_prev_q & scl_s;
    bit_val       = sda_s;
  end

  AST_RISE_NOT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> !(start_det || stop_det)); // R4
endmodule

// File: rtl/snoop_addr_capture.sv
module snoop_addr_capture #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  abort,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_q
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (abort) begin
      cnt_d = CNT_FULL;
    end else if (bit_stb && (cnt_q < CNT_FULL)) begin
      sh_d   = {sh_q[FRAME_BITS-2:0], bit_val};
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == CNT_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_FULL;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign frame_done = done_q;
  assign frame_q    = sh_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !restart) |=> !frame_done); // R12
endmodule

// File: rtl/bus_snoop_monitor.sv
module bus_snoop_monitor
  import snoop_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_in,
  input  logic              scl_in,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              bus_busy,
  output logic              addr_valid,
  output logic              addr_match,
  output logic              rw_bit,
  output logic              tx_allowed
);
  localparam int FRAME_BITS = ADDR_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [1:0] line_s;
  snoop_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  ({sda_in, scl_in}),
    .dout (line_s)
  );

  logic start_det, stop_det, scl_rise, bit_val;
  snoop_cond_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sda_s    (line_s[1]),
    .scl_s    (line_s[0]),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .bit_val  (bit_val)
  );

  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_q;
  snoop_addr_capture #(.FRAME_BITS(FRAME_BITS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .restart   (start_det),
    .abort     (stop_det),
    .bit_stb   (scl_rise),
    .bit_val   (bit_val),
    .frame_done(frame_done),
    .frame_q   (frame_q)
  );

  phase_e phase_q, phase_d;
  logic   start_q, start_d;
  logic   stop_q, stop_d;
  logic   valid_q, valid_d;
  logic   match_q, match_d;
  logic   rw_q, rw_d;
  logic   own_hit;
  logic   capture_end;

  always_comb begin
    own_hit     = (frame_q[FRAME_BITS-1:1] == own_addr);
    capture_end = frame_done && (phase_q == PH_ADDR);
    start_d     = start_det;
    stop_d      = stop_det;
    valid_d     = capture_end;
    phase_d     = phase_q;
    match_d     = match_q;
    rw_d        = rw_q;
    if (start_det) begin
      phase_d = PH_ADDR;
      match_d = 1'b0;
      rw_d    = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_FREE;
    end else if (capture_end) begin
      phase_d = own_hit ? PH_OWNED : PH_HELD;
      match_d = own_hit;
      rw_d    = frame_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      phase_q <= PH_FREE;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      valid_q <= 1'b0;
      match_q <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      valid_q <= valid_d;
      match_q <= match_d;
      rw_q    <= rw_d;
    end
  end

  assign start_pulse = start_q;
  assign stop_pulse  = stop_q;
  assign bus_busy    = (phase_q != PH_FREE);
  assign addr_valid  = valid_q;
  assign addr_match  = match_q;
  assign rw_bit      = rw_q;
  assign tx_allowed  = (phase_q == PH_FREE) || (phase_q == PH_OWNED);

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_core_n)
    start_det |=> (bus_busy && start_pulse)); // R2
  AST_FREE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_core_n)
    stop_det |=> (!bus_busy && tx_allowed && stop_pulse)); // R3
  AST_HOLD_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_core_n)
    start_pulse |-> !tx_allowed); // R8
  AST_HOLD_FOREIGN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr_valid && !addr_match) |-> !tx_allowed); // R7
  AST_GRANT_OWN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr_valid && addr_match) |-> tx_allowed); // R6
  AST_MATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!start_pulse && !addr_valid) |-> ($stable(addr_match) && $stable(rw_bit))); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({start_pulse, stop_pulse, addr_valid})); // R5
endmodule

// File: tb/bus_snoop_monitor_test.sv
module bus_snoop_monitor_test;
  localparam int H = 4;
  localparam logic [6:0] OWN = 7'h2A;
  localparam int NV = 6;
  // {addr7, rw, expected match, expected tx_allowed after valid}
  localparam logic [9:0] VEC [NV] = '{
    {7'h2A, 1'b1, 1'b1, 1'b1},
    {7'h2A, 1'b0, 1'b1, 1'b1},
    {7'h2B, 1'b1, 1'b0, 1'b0},
    {7'h6A, 1'b0, 1'b0, 1'b0},
    {7'h00, 1'b0, 1'b0, 1'b0},
    {7'h7F, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda = 1'b1;
  logic scl = 1'b1;
  logic start_pulse, stop_pulse, bus_busy, addr_valid, addr_match, rw_bit, tx_allowed;
  int checks = 0;
  int errors = 0;
  int n_start = 0, n_stop = 0, n_valid = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_snoop_monitor uut (
    .clk(clk), .rst_n(rst_n), .sda_in(sda), .scl_in(scl), .own_addr(OWN),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_busy(bus_busy),
    .addr_valid(addr_valid), .addr_match(addr_match), .rw_bit(rw_bit),
    .tx_allowed(tx_allowed)
  );

  always @(negedge clk) begin
    if (start_pulse) n_start++;
    if (stop_pulse)  n_stop++;
    if (addr_valid)  n_valid++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda = 1'b0; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic do_rstart();
    sda = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    sda = 1'b0; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    sda = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    sda = 1'b1; wt(H);
    wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda = b;    wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int b = 7; b >= 0; b--) send_bit(v[b]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, p0, v0;
    wt(3);
    rst_n = 1'b1;
    wt(8);
    // R1 reset state
    chk("R1 busy", bus_busy, 0);
    chk("R1 tx_allowed", tx_allowed, 1);
    chk("R1 match", addr_match, 0);
    chk("R1 rw", rw_bit, 0);
    chk("R1 pulses", n_start + n_stop + n_valid, 0);

    // R4 / R11: data toggles with clock low, clock pulses on a free bus
    scl = 1'b0; wt(H);
    for (int i = 0; i < 4; i++) begin sda = ~sda; wt(H); end
    for (int i = 0; i < 9; i++) send_bit(i[0]);
    sda = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    chk("R4 no framing on low-clock toggles", n_start + n_stop, 0);
    chk("R4 busy unchanged", bus_busy, 0);
    chk("R11 no addr_valid on free bus", n_valid, 0);

    // table of address bytes
    for (int i = 0; i < NV; i++) begin
      s0 = n_start; p0 = n_stop; v0 = n_valid;
      do_start();
      chk("R2 one start pulse", n_start - s0, 1);
      chk("R2 busy after start", bus_busy, 1);
      send_bit(VEC[i][9]); send_bit(VEC[i][8]); send_bit(VEC[i][7]);
      chk("R8 tx blocked during address", tx_allowed, 0);
      for (int b = 6; b >= 0; b--) if (b < 4) send_bit(VEC[i][b+3]);
      send_bit(VEC[i][2]);
      chk("R5 one addr_valid", n_valid - v0, 1);
      chk("R5 rw bit", rw_bit, VEC[i][2]);
      chk("R6 match", addr_match, VEC[i][1]);
      chk(VEC[i][1] ? "R6 tx granted" : "R7 tx held", tx_allowed, VEC[i][0]);
      send_bit(1'b0);
      send_bit(1'b1);
      chk("R9 no extra addr_valid", n_valid - v0, 1);
      chk("R9 match kept", addr_match, VEC[i][1]);
      chk("R9 rw kept", rw_bit, VEC[i][2]);
      chk("R7 tx still per address", tx_allowed, VEC[i][0]);
      chk("R4 no stop from data", n_stop - p0, 0);
      do_stop();
      chk("R3 one stop pulse", n_stop - p0, 1);
      chk("R3 busy cleared", bus_busy, 0);
      chk("R3 tx allowed", tx_allowed, 1);
    end

    // R10 repeated start after a foreign read address
    s0 = n_start; p0 = n_stop; v0 = n_valid;
    do_start();
    send_byte({7'h55, 1'b1});
    chk("R7 foreign held", tx_allowed, 0);
    chk("R10 rw before restart", rw_bit, 1);
    do_rstart();
    chk("R10 busy kept", bus_busy, 1);
    chk("R10 no stop", n_stop - p0, 0);
    chk("R10 second start", n_start - s0, 2);
    chk("R10 rw cleared", rw_bit, 0);
    chk("R10 tx blocked", tx_allowed, 0);
    send_byte({OWN, 1'b0});
    chk("R10 new valid", n_valid - v0, 2);
    chk("R10 new match", addr_match, 1);
    chk("R10 tx granted", tx_allowed, 1);
    do_stop();
    chk("R3 free after restart frame", bus_busy, 0);

    // R12 stop in the middle of an address
    v0 = n_valid;
    do_start();
    for (int i = 0; i < 4; i++) send_bit(OWN[6-i]);
    do_stop();
    chk("R12 busy cleared", bus_busy, 0);
    scl = 1'b0; wt(H);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    sda = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    chk("R12 no addr_valid after abort", n_valid - v0, 0);
    chk("R12 tx allowed", tx_allowed, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule